// File: doc/BRIEF.md
# Monotonic Timestamp Extender

This block turns a periodic down-counter, which wraps once per tick, into a free-running 32-bit timestamp. It keeps its own count of ticks, raised by one for every cycle in which the tick-increment input is high. When a read is requested, the block takes the tick count as it stood before that clock edge. In the same edge it takes the down-counter snapshot that the surrounding logic presents. Because the tick count is taken first, it may lag the snapshot but can never run ahead of it.

The raw snapshot is not trusted. A value above the reload constant is replaced by reload minus one, and the block pulses a request to reprogram the timer with its reload value. A value that has risen since the previous read, while the tick count has not changed, is replaced by the previous value. The corrected count and the tick count are then kept as the reference for the next read.

The result is tick × reload + (reload − 1 − count), computed modulo 2^32. It is presented with a valid strobe one cycle after the request.

Top module: `ts_extender`

## Requirements
- R1: After reset, rd_valid, reprog_req and timestamp are all zero, and the held previous count and previous tick are zero.
- R2: rd_valid is high in the cycle after each cycle in which rd_req is high, and low otherwise.
- R3: The internal tick count starts at zero and rises by exactly one for each clock edge at which tick_inc is high.
- R4: When tick_inc and rd_req are high at the same edge, the read uses the tick count from before that increment.
- R5: A snapshot strictly greater than RELOAD is replaced by RELOAD−1, and reprog_req is high together with rd_valid for that read. reprog_req is low for every other read.
- R6: If the snapshot, after the R5 correction, is greater than the held previous count and the tick count equals the held previous tick, the held previous count is used instead.
- R7: Every read stores its corrected count and its tick count as the new held previous values.
- R8: timestamp = (tick × RELOAD + RELOAD − 1 − count) mod 2^32, where count is the corrected count.
- R9: A snapshot exactly equal to RELOAD is not in range for R5 and is used unchanged, subject only to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_inc | input | 1 | Raises the tick count by one at this edge |
| rd_req | input | 1 | Read request; takes the tick count and the snapshot at this edge |
| cnt_snap | input | 16 | Current value of the wrapping down-counter |
| rd_valid | output | 1 | Result strobe, one cycle after rd_req |
| timestamp | output | 32 | Extended timestamp, valid with rd_valid |
| reprog_req | output | 1 | Asks for the timer to be reloaded with RELOAD; valid with rd_valid |

## Verification
Every read result appears at the first clock edge after the edge that accepted the request. rd_valid, timestamp and reprog_req can therefore all be checked one cycle after rd_req. A tick increment counts toward any read accepted at a later edge, and is not seen by a read in its own edge. The bench drives inputs on the falling edge and samples on the following falling edge, half a cycle after the result registers update. Its reference model tracks ticks and the previous-value pair itself, advancing them in the same order the requirements give.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;

  localparam int unsigned CNT_W = 16;
  localparam int unsigned TS_W  = 32;

  // Range correction: counts above the reload are replaced by reload-1.
  function automatic logic [CNT_W-1:0] fix_range(input logic [CNT_W-1:0] raw,
                                                 input logic [CNT_W-1:0] reload);
    if (raw > reload) return reload - 16'd1;
    return raw;
  endfunction

  // Backward-motion correction within one tick.
  function automatic logic [CNT_W-1:0] fix_backward(input logic [CNT_W-1:0] cnt,
                                                    input logic [CNT_W-1:0] prev_cnt,
                                                    input logic             same_tick);
    if (same_tick && (cnt > prev_cnt)) return prev_cnt;
    return cnt;
  endfunction

  // Timestamp = tick*reload + (reload-1-count), modulo 2^TS_W.
  function automatic logic [TS_W-1:0] compose(input logic [TS_W-1:0]  tick,
                                              input logic [CNT_W-1:0] cnt,
                                              input logic [CNT_W-1:0] reload);
    logic [TS_W-1:0] base;
    logic [TS_W-1:0] part;
    base = tick * TS_W'(reload);
    part = TS_W'(reload) - TS_W'(1) - TS_W'(cnt);
    return base + part;
  endfunction

endpackage

// File: rtl/ts_tick_counter.sv
module ts_tick_counter #(
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_inc,
  output logic [TICK_W-1:0] tick_now
);

  logic [TICK_W-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        tick_q <= '0;
    else if (tick_inc) tick_q <= tick_q + 1'b1;
  end

  assign tick_now = tick_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_inc |=> (tick_q == $past(tick_q) + 1'b1)); // R3
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_inc |=> $stable(tick_q)); // R3

endmodule

// File: rtl/ts_count_fix.sv
module ts_count_fix
  import ts_ext_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter logic [CNT_W-1:0] RELOAD = 16'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [TICK_W-1:0] tick_now,
  input  logic [CNT_W-1:0]  raw_cnt,
  output logic [CNT_W-1:0]  fixed_cnt,
  output logic              out_of_range
);

  logic [CNT_W-1:0]  prev_cnt;
  logic [TICK_W-1:0] prev_tick;
  logic [CNT_W-1:0]  ranged_cnt;
  logic              same_tick;
  logic              held_back;

  always_comb begin
    ranged_cnt   = fix_range(raw_cnt, RELOAD);
    out_of_range = (raw_cnt > RELOAD);
    same_tick    = (tick_now == prev_tick);
    fixed_cnt    = fix_backward(ranged_cnt, prev_cnt, same_tick);
    held_back    = (fixed_cnt != ranged_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cnt  <= '0;
      prev_tick <= '0;
    end else if (rd_req) begin
      prev_cnt  <= fixed_cnt;
      prev_tick <= tick_now;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (fixed_cnt <= RELOAD)); // R5
  AST_NO_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && tick_now == prev_tick) |-> (fixed_cnt <= prev_cnt)); // R6
  AST_HOLD_ONLY_SAME_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && held_back) |-> (tick_now == prev_tick)); // R6
  AST_PREV_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (prev_tick == $past(tick_now))); // R7

endmodule

// File: rtl/ts_compose.sv
module ts_compose
  import ts_ext_pkg::*;
#(
  parameter int unsigned TICK_W = 32,
  parameter logic [CNT_W-1:0] RELOAD = 16'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [TICK_W-1:0] tick_used,
  input  logic [CNT_W-1:0]  fixed_cnt,
  input  logic              out_of_range,
  output logic              rd_valid,
  output logic [TS_W-1:0]   timestamp,
  output logic              reprog_req
);

  logic [TS_W-1:0] ts_d;

  always_comb ts_d = compose(TS_W'(tick_used), fixed_cnt, RELOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      reprog_req <= 1'b0;
      timestamp  <= '0;
    end else begin
      rd_valid   <= rd_req;
      reprog_req <= rd_req & out_of_range;
      if (rd_req) timestamp <= ts_d;
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R2
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R2
  AST_REPROG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    reprog_req |-> rd_valid); // R5

endmodule

// File: rtl/ts_extender.sv
module ts_extender
  import ts_ext_pkg::*;
#(
  parameter logic [15:0] RELOAD = 16'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_inc,
  input  logic        rd_req,
  input  logic [15:0] cnt_snap,
  output logic        rd_valid,
  output logic [31:0] timestamp,
  output logic        reprog_req
);

  localparam int unsigned TICK_W = TS_W;

  logic [TICK_W-1:0] tick_now;
  logic [CNT_W-1:0]  fixed_cnt;
  logic              out_of_range;

  ts_tick_counter #(.TICK_W(TICK_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_inc (tick_inc),
    .tick_now (tick_now)
  );

  ts_count_fix #(.TICK_W(TICK_W), .RELOAD(RELOAD)) u_fix (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .tick_now     (tick_now),
    .raw_cnt      (cnt_snap),
    .fixed_cnt    (fixed_cnt),
    .out_of_range (out_of_range)
  );

  ts_compose #(.TICK_W(TICK_W), .RELOAD(RELOAD)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .tick_used    (tick_now),
    .fixed_cnt    (fixed_cnt),
    .out_of_range (out_of_range),
    .rd_valid     (rd_valid),
    .timestamp    (timestamp),
    .reprog_req   (reprog_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && !reprog_req && timestamp == 32'd0)); // R1

endmodule

// File: tb/ts_extender_test.sv
module ts_extender_test;

  localparam int R  = 12;
  localparam int RW = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_inc = 1'b0, rd_req = 1'b0;
  logic [15:0] cnt_snap = '0;
  logic        rd_valid, reprog_req;
  logic [31:0] timestamp;

  logic        w_tick = 1'b0, w_req = 1'b0;
  logic [15:0] w_snap = '0;
  logic        w_valid, w_reprog;
  logic [31:0] w_ts;

  int nchk = 0, nfail = 0;
  longint m_tick = 0, m_prev_cnt = 0, m_prev_tick = 0;

  always #10 clk = ~clk;

  ts_extender #(.RELOAD(16'(R))) uut (
    .clk(clk), .rst_n(rst_n), .tick_inc(tick_inc), .rd_req(rd_req),
    .cnt_snap(cnt_snap), .rd_valid(rd_valid), .timestamp(timestamp),
    .reprog_req(reprog_req));

  ts_extender #(.RELOAD(16'(RW))) uut_wide (
    .clk(clk), .rst_n(rst_n), .tick_inc(w_tick), .rd_req(w_req),
    .cnt_snap(w_snap), .rd_valid(w_valid), .timestamp(w_ts),
    .reprog_req(w_reprog));

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint wrap32(input longint v);
    longint m;
    m = 64'd4294967296;
    return ((v % m) + m) % m;
  endfunction

  // One read on the small instance; model follows R4..R9 independently.
  task automatic do_read(input int snap, input bit with_tick, input string tag);
    longint used, c, exp_ts;
    bit oob;
    @(negedge clk);
    rd_req = 1'b1; cnt_snap = 16'(snap); tick_inc = with_tick;
    used = m_tick;                       // R4: pre-increment tick
    if (with_tick) m_tick++;
    oob = (snap > R);                    // R5 / R9: equal is in range
    c = oob ? R - 1 : snap;
    if (used == m_prev_tick && c > m_prev_cnt) c = m_prev_cnt;  // R6
    m_prev_cnt = c; m_prev_tick = used;  // R7
    exp_ts = wrap32(used * R + (R - 1) - c);  // R8
    @(negedge clk);
    rd_req = 1'b0; tick_inc = 1'b0;
    check({tag, " R2 valid"}, rd_valid, 1);
    check({tag, " R8 timestamp"}, timestamp, exp_ts);
    check({tag, " R5 reprog"}, reprog_req, oob);
    @(negedge clk);
    check({tag, " R2 valid low"}, rd_valid, 0);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_inc = 1'b1;
    @(negedge clk);
    tick_inc = 1'b0;
    m_tick++;                            // R3
  endtask

  initial begin
    #(20 * 190000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", rd_valid, 0);
    check("R1 reprog", reprog_req, 0);
    check("R1 timestamp", timestamp, 0);
    rst_n = 1'b1;
    // R1/R7: first read at tick 0 is held to the zero previous count
    do_read(7, 0, "first");
    // R9: snapshot equal to reload after a fresh tick is used as is
    do_tick();
    do_read(R, 0, "R9 equal");
    // Sweep: each tick, ascending then descending snapshots incl. out of range (R5, R6)
    for (int t = 0; t < 5; t++) begin
      do_tick();
      for (int s = 0; s < 16; s++) do_read(s, 0, "R6 up");
      for (int s = 15; s >= 0; s--) do_read(s, 0, "R6 down");
    end
    // R4: read and tick at the same edge, then read after the new tick
    for (int s = 3; s < 16; s += 4) begin
      do_read(s, 1, "R4 same-edge");
      do_read(s, 0, "R4 after");
    end
    // R3: several ticks in a row, then a read reflects them all
    @(negedge clk); tick_inc = 1'b1;
    repeat (9) @(negedge clk);
    tick_inc = 1'b0; m_tick += 9;
    do_read(14, 0, "R3 burst");
    do_read(2, 0, "R3 burst low");
    // R8 wrap: wide reload, tick beyond 2^32/65535
    @(negedge clk); w_tick = 1'b1;
    repeat (65540) @(negedge clk);
    w_tick = 1'b0;
    @(negedge clk); w_req = 1'b1; w_snap = 16'd100;
    @(negedge clk); w_req = 1'b0;
    check("R8 wide valid", w_valid, 1);
    check("R8 wide wrap", w_ts, wrap32(longint'(65540) * RW + RW - 1 - 100));
    check("R5 wide reprog", w_reprog, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule